// File: doc/BRIEF.md
# Progress-Synchronizing Shared Cache Arbiter

Two video decoders issue motion-compensation fetch requests into a single shared cache port. This arbiter chooses which of the two requests is offered to the cache in each cycle and returns a per-requester ready signal when the cache accepts it. Each decoder also reports the address of the macroblock it is currently decoding. The arbiter uses those positions to keep the two decoders close together when a synchronization mode is on. Their reference windows then overlap in time, and samples that one decoder has already fetched can be reused by the other.

With synchronization on, a conflict goes to the decoder that has made less progress. The gap between the two positions is taken as an absolute difference. When that gap exceeds a programmable limit, the decoder that is ahead is held off entirely until the gap narrows again. With synchronization off (for example, when one frame depends on the other), the arbiter alternates between requesters in round-robin order and ignores the positions. Requests use valid/ready handshakes. A held-off requester keeps its request and sees ready low, so nothing is dropped or reordered.

Top module: `sync_cache_arb`

## Requirements
- R1: While rst_n is low, grant is 2'b00 and both ready outputs are low. After reset the gap limit holds 2, the round-robin preference points at requester A, and the tie preference points at requester A.
- R2: With sync_en high, both requests valid, neither held off and unequal positions, the requester with the smaller position is granted (grant bit 0 = A, bit 1 = B).
- R3: With sync_en high and the absolute position gap strictly greater than the limit, the requester with the larger position receives no grant and no ready while its valid stays high. The other requester is served as usual.
- R4: The hold-off ends in the first cycle in which the gap is at or below the limit, with no extra delay.
- R5: With sync_en high, both valid and equal positions, the tie preference picks the winner. It flips to the other requester only when a tie-decided request is accepted (cache_ready high).
- R6: With sync_en low, no requester is held off whatever the gap. On a conflict the round-robin preference wins, and after any accepted request the preference moves to the requester that was not served.
- R7: grant is one-hot or zero and only marks a valid requester. cache_valid is high exactly when some requester is valid and not held off. a_ready/b_ready are the matching grant bit ANDed with cache_ready.
- R8: A cycle with gap_wr high loads gap_wdata into the limit at the clock edge. The new limit governs hold-off from the next cycle on.
- R9: The gap is symmetric: either requester can be the one held off, depending on which position is larger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_en | input | 1 | Enables progress synchronization |
| gap_wr | input | 1 | Load strobe for the gap limit |
| gap_wdata | input | TW | New gap limit value |
| pos_a | input | AW | Current macroblock address of requester A |
| pos_b | input | AW | Current macroblock address of requester B |
| a_valid | input | 1 | Requester A has a request |
| a_ready | output | 1 | Requester A's request accepted this cycle |
| b_valid | input | 1 | Requester B has a request |
| b_ready | output | 1 | Requester B's request accepted this cycle |
| cache_valid | output | 1 | A request is offered to the cache |
| cache_ready | input | 1 | Cache accepts the offered request |
| grant | output | 2 | One-hot selection, bit 0 = A, bit 1 = B |

## Verification
The assertions check on every cycle that grant is one-hot, that only valid requesters are granted, that a held-off requester is never granted, that the offered request appears exactly when something is eligible, and that the lower position wins a synchronized conflict. Alternation after an accepted tie or round-robin transfer is also checked cycle to cycle. Some behaviours need a sequence of cycles to show and are left to the bench's scenarios: the limit taking its reset value of 2, a programmed limit taking effect one cycle after the write, the hold-off lifting at exactly the limit, and the tie preference staying put while the cache stalls.

// File: rtl/sync_arb_pkg.sv
package sync_arb_pkg;
  typedef enum logic {SIDE_A = 1'b0, SIDE_B = 1'b1} side_e;

  // one-hot grant vector for a side
  function automatic logic [1:0] side_onehot(input side_e s);
    return (s == SIDE_B) ? 2'b10 : 2'b01;
  endfunction

  function automatic side_e other_side(input side_e s);
    return (s == SIDE_B) ? SIDE_A : SIDE_B;
  endfunction
endpackage

// File: rtl/sync_gap_unit.sv
module sync_gap_unit #(
  parameter int AW = 12,
  parameter int TW = 8
) (
  input  logic [AW-1:0] pos_a,
  input  logic [AW-1:0] pos_b,
  input  logic [TW-1:0] limit,
  input  logic          sync_en,
  output logic          pos_lt,
  output logic          pos_eq,
  output logic [1:0]    blk
);
  localparam int CW = (AW > TW) ? AW : TW;

  function automatic logic [AW-1:0] abs_gap(input logic [AW-1:0] x, input logic [AW-1:0] y);
    return (x > y) ? (x - y) : (y - x);
  endfunction

  logic [AW-1:0] gap;
  logic [CW-1:0] gap_ext, lim_ext;
  logic          over;

  assign gap     = abs_gap(pos_a, pos_b);
  assign gap_ext = CW'(gap);
  assign lim_ext = CW'(limit);
  assign over    = gap_ext > lim_ext;
  assign pos_lt  = pos_a < pos_b;
  assign pos_eq  = pos_a == pos_b;

  // the side that is ahead is held off while the gap is too wide
  assign blk[0] = sync_en & over & (pos_a > pos_b);
  assign blk[1] = sync_en & over & (pos_b > pos_a);
endmodule

// File: rtl/sync_pick.sv
module sync_pick
  import sync_arb_pkg::*;
(
  input  logic [1:0] elig,
  input  logic       sync_en,
  input  logic       pos_lt,
  input  logic       pos_eq,
  input  side_e      tie_ptr,
  input  side_e      rr_ptr,
  output logic [1:0] grant,
  output logic       tie_case
);
  side_e pref;
  logic  both;

  assign both = &elig;

  always_comb begin
    if (sync_en) begin
      if (pos_eq)      pref = tie_ptr;
      else if (pos_lt) pref = SIDE_A;
      else             pref = SIDE_B;
    end else begin
      pref = rr_ptr;
    end
  end

  assign grant    = both ? side_onehot(pref) : elig;
  assign tie_case = sync_en & both & pos_eq;
endmodule

// File: rtl/sync_ptr_regs.sv
module sync_ptr_regs
  import sync_arb_pkg::*;
#(
  parameter int TW      = 8,
  parameter int DEF_GAP = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          xfer,
  input  side_e         winner,
  input  logic          sync_en,
  input  logic          tie_case,
  input  logic          gap_wr,
  input  logic [TW-1:0] gap_wdata,
  output side_e         rr_ptr,
  output side_e         tie_ptr,
  output logic [TW-1:0] limit
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rr_ptr  <= SIDE_A;
      tie_ptr <= SIDE_A;
      limit   <= TW'(DEF_GAP);
    end else begin
      if (xfer && !sync_en) rr_ptr  <= other_side(winner);
      if (xfer && tie_case) tie_ptr <= other_side(winner);
      if (gap_wr)           limit   <= gap_wdata;
    end
  end
endmodule

// File: rtl/sync_cache_arb.sv
module sync_cache_arb
  import sync_arb_pkg::*;
#(
  parameter int AW      = 12,
  parameter int TW      = 8,
  parameter int DEF_GAP = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync_en,
  input  logic          gap_wr,
  input  logic [TW-1:0] gap_wdata,
  input  logic [AW-1:0] pos_a,
  input  logic [AW-1:0] pos_b,
  input  logic          a_valid,
  output logic          a_ready,
  input  logic          b_valid,
  output logic          b_ready,
  output logic          cache_valid,
  input  logic          cache_ready,
  output logic [1:0]    grant
);
  logic [1:0]    req, elig, blk, grant_raw, rdy;
  logic          pos_lt, pos_eq, tie_case, xfer;
  logic [TW-1:0] limit;
  side_e         rr_ptr, tie_ptr, winner;

  assign req = {b_valid, a_valid};

  sync_gap_unit #(.AW(AW), .TW(TW)) u_gap (
    .pos_a(pos_a), .pos_b(pos_b), .limit(limit), .sync_en(sync_en),
    .pos_lt(pos_lt), .pos_eq(pos_eq), .blk(blk)
  );

  for (genvar i = 0; i < 2; i++) begin : g_side
    assign elig[i] = req[i] & ~blk[i];
    assign rdy[i]  = grant[i] & cache_ready;
  end

  sync_pick u_pick (
    .elig(elig), .sync_en(sync_en), .pos_lt(pos_lt), .pos_eq(pos_eq),
    .tie_ptr(tie_ptr), .rr_ptr(rr_ptr), .grant(grant_raw), .tie_case(tie_case)
  );

  assign grant       = rst_n ? grant_raw : 2'b00;
  assign cache_valid = |grant;
  assign xfer        = cache_valid & cache_ready;
  assign winner      = grant[1] ? SIDE_B : SIDE_A;
  assign a_ready     = rdy[0];
  assign b_ready     = rdy[1];

  sync_ptr_regs #(.TW(TW), .DEF_GAP(DEF_GAP)) u_regs (
    .clk(clk), .rst_n(rst_n), .xfer(xfer), .winner(winner), .sync_en(sync_en),
    .tie_case(tie_case), .gap_wr(gap_wr), .gap_wdata(gap_wdata),
    .rr_ptr(rr_ptr), .tie_ptr(tie_ptr), .limit(limit)
  );
endmodule

// File: rtl/sync_cache_arb_chk.sv
module sync_cache_arb_chk #(
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sync_en,
  input logic [AW-1:0] pos_a,
  input logic [AW-1:0] pos_b,
  input logic          a_valid,
  input logic          b_valid,
  input logic          cache_valid,
  input logic          cache_ready,
  input logic [1:0]    grant,
  input logic [1:0]    blk,
  input logic          tie_case,
  input logic          xfer
);
  // R7
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(grant));
  // R7
  grant_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant[0] |-> a_valid) and (grant[1] |-> b_valid));
  // R7
  offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cache_valid == ((a_valid && !blk[0]) || (b_valid && !blk[1])));
  // R3
  held_a_chk: assert property (@(posedge clk) disable iff (!rst_n) blk[0] |-> !grant[0]);
  // R3
  held_b_chk: assert property (@(posedge clk) disable iff (!rst_n) blk[1] |-> !grant[1]);
  // R2
  lower_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_en && a_valid && b_valid && blk == 2'b00 && pos_a != pos_b)
      |-> (grant == ((pos_a < pos_b) ? 2'b01 : 2'b10)));
  // R5
  tie_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tie_case && xfer && grant[0]) |=> (!tie_case || grant[1]));
  // R6
  rr_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_en && xfer && grant[0]) |=> (sync_en || !(a_valid && b_valid) || grant[1]));
endmodule

bind sync_cache_arb sync_cache_arb_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sync_en(sync_en), .pos_a(pos_a), .pos_b(pos_b),
  .a_valid(a_valid), .b_valid(b_valid), .cache_valid(cache_valid),
  .cache_ready(cache_ready), .grant(grant), .blk(blk), .tie_case(tie_case), .xfer(xfer)
);

// File: tb/sync_cache_arb_tb.sv
module sync_cache_arb_tb;
  localparam int AW = 12;
  localparam int TW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sync_en = 1'b0, gap_wr = 1'b0, a_valid = 1'b0, b_valid = 1'b0, cache_ready = 1'b0;
  logic [TW-1:0] gap_wdata = '0;
  logic [AW-1:0] pos_a = '0, pos_b = '0;
  logic          a_ready, b_ready, cache_valid;
  logic [1:0]    grant;

  int  n_tests = 0, n_fail = 0;
  bit  done = 0;
  // reference state: preference 0 = A, 1 = B
  int  m_limit = 2, m_rr = 0, m_tie = 0;

  always #4 clk = ~clk;

  sync_cache_arb #(.AW(AW), .TW(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .sync_en(sync_en), .gap_wr(gap_wr), .gap_wdata(gap_wdata),
    .pos_a(pos_a), .pos_b(pos_b), .a_valid(a_valid), .a_ready(a_ready),
    .b_valid(b_valid), .b_ready(b_ready), .cache_valid(cache_valid),
    .cache_ready(cache_ready), .grant(grant)
  );

  task automatic step(input bit av, input bit bv, input int pa, input int pb,
                      input bit en, input bit cr, input bit wr, input int wd, input string tag);
    int  gap, who;
    bit  hold_a, hold_b, ea, eb;
    logic [1:0] exp_g;
    a_valid = av; b_valid = bv; pos_a = AW'(pa); pos_b = AW'(pb);
    sync_en = en; cache_ready = cr; gap_wr = wr; gap_wdata = TW'(wd);
    #1;
    gap    = (pa > pb) ? pa - pb : pb - pa;
    hold_a = en && gap > m_limit && pa > pb;
    hold_b = en && gap > m_limit && pb > pa;
    ea = av && !hold_a;
    eb = bv && !hold_b;
    who = -1;
    if (ea && eb) begin
      if (!en)          who = m_rr;
      else if (pa < pb) who = 0;
      else if (pb < pa) who = 1;
      else              who = m_tie;
    end else if (ea) who = 0;
    else if (eb)     who = 1;
    if (!rst_n) who = -1;
    exp_g = (who == 0) ? 2'b01 : (who == 1) ? 2'b10 : 2'b00;
    n_tests++;
    if (grant !== exp_g || cache_valid !== (who >= 0) ||
        a_ready !== (who == 0 && cr) || b_ready !== (who == 1 && cr)) begin
      n_fail++;
      $display("FAIL %s: grant=%b cv=%b ar=%b br=%b expected grant=%b cv=%b ar=%b br=%b",
               tag, grant, cache_valid, a_ready, b_ready, exp_g, (who >= 0),
               (who == 0 && cr), (who == 1 && cr));
    end
    @(posedge clk);
    if (!rst_n) begin
      m_limit = 2; m_rr = 0; m_tie = 0;
    end else begin
      if (who >= 0 && cr) begin
        if (!en) m_rr = 1 - who;
        else if (ea && eb && pa == pb) m_tie = 1 - who;
      end
      if (wr) m_limit = wd;
    end
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R1 reset holds everything off
    step(1, 1, 5, 5, 1, 1, 0, 0, "R1");
    step(1, 0, 5, 9, 0, 1, 0, 0, "R1");
    rst_n = 1'b1;
    // R1 default limit 2: gap 3 holds A, gap 2 does not
    step(1, 0, 13, 10, 1, 1, 0, 0, "R1");
    step(1, 0, 12, 10, 1, 1, 0, 0, "R1");
    // R2 lower position wins
    step(1, 1, 10, 11, 1, 1, 0, 0, "R2");
    step(1, 1, 12, 11, 1, 1, 0, 0, "R2");
    step(1, 1, 30, 31, 1, 0, 0, 0, "R2");
    // R3 ahead requester held; the other served
    step(1, 1, 20, 16, 1, 1, 0, 0, "R3");
    step(1, 0, 20, 16, 1, 1, 0, 0, "R3");
    step(1, 0, 20, 16, 1, 1, 0, 0, "R3");
    // R4 lifts at gap == limit
    step(1, 0, 20, 18, 1, 1, 0, 0, "R4");
    // R5 ties alternate, stall keeps preference
    step(1, 1, 40, 40, 1, 1, 0, 0, "R5");
    step(1, 1, 40, 40, 1, 0, 0, 0, "R5");
    step(1, 1, 40, 40, 1, 0, 0, 0, "R5");
    step(1, 1, 40, 40, 1, 1, 0, 0, "R5");
    step(1, 1, 40, 40, 1, 1, 0, 0, "R5");
    // R6 round robin, no hold-off when sync is off
    step(1, 0, 900, 3, 0, 1, 0, 0, "R6");
    step(1, 1, 900, 3, 0, 1, 0, 0, "R6");
    step(1, 1, 900, 3, 0, 1, 0, 0, "R6");
    step(1, 1, 900, 3, 0, 0, 0, 0, "R6");
    step(1, 1, 3, 900, 0, 1, 0, 0, "R6");
    // R8 program limit 5
    step(0, 0, 0, 0, 1, 1, 1, 5, "R8");
    step(1, 0, 15, 10, 1, 1, 0, 0, "R8");
    step(1, 0, 16, 10, 1, 1, 0, 0, "R8");
    // R9 symmetric: B ahead
    step(0, 1, 10, 16, 1, 1, 0, 0, "R9");
    step(1, 1, 10, 16, 1, 1, 0, 0, "R9");
    step(0, 1, 10, 15, 1, 1, 0, 0, "R9");
    // R8 limit 0: any difference holds the leader
    step(0, 0, 0, 0, 1, 1, 1, 0, "R8");
    step(1, 1, 7, 8, 1, 1, 0, 0, "R8");
    step(0, 1, 7, 8, 1, 1, 0, 0, "R8");
    // R7 mixed random traffic
    for (int i = 0; i < 3000; i++) begin
      int base = 200 + int'($urandom_range(0, 20));
      step($urandom_range(0, 1), $urandom_range(0, 1),
           base + int'($urandom_range(0, 7)), base + int'($urandom_range(0, 7)),
           $urandom_range(0, 3) != 0, $urandom_range(0, 3) != 0,
           $urandom_range(0, 40) == 0, int'($urandom_range(0, 5)), "R7");
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule